// File: doc/BRIEF.md
# Compressed trap-value address register

This block holds the faulting virtual address that a trap records, but stores fewer bits than the register width. Only the low VASIZE address bits are kept, along with one extra bit. That extra bit acts as the sign of a two's-complement value one bit wider than the largest virtual address. A read sign-extends the stored value back to XLEN bits.

The recoding is chosen with two goals. Every properly sign-extended virtual address comes back exactly as written. Every address whose upper bits are not a proper sign extension still reads back as an improperly extended address, even though its original upper bits are gone.

There are two write paths. Trap hardware uses a valid strobe with a full-width address, and the recoding above applies to it. Software uses a CSR write strobe, and its data is always treated as a valid address. When both strobes are active in the same cycle, the trap write is taken. A build parameter can select full-width storage instead, in which case the register keeps every bit with no recoding.

Top module: `tval_compress_reg`

## Requirements
- R1: Synchronous active-high reset clears the storage, so `rd_data` reads zero in the cycle after a reset edge.
- R2: After a trap write of an address whose bits XLEN-1..VASIZE all equal bit VASIZE-1, `rd_data` equals that address exactly.
- R3: After a trap write of any other address, `rd_data[VASIZE-1:0]` equals the address's low bits and `rd_data[XLEN-1:VASIZE]` is all copies of the inverse of address bit VASIZE-1, so the readback is still improperly extended.
- R4: After a software write, `rd_data[VASIZE-1:0]` equals the written data's low bits and every bit above equals data bit VASIZE-1; the written upper bits have no effect.
- R5: When `trap_vld` and `csr_we` are both high at a clock edge, the trap address is stored and the software data is discarded.
- R6: With neither strobe high, `rd_data` holds its value.
- R7: `rd_data` is driven combinationally from storage; a write becomes visible in the cycle after its strobe and not before.
- R8: With FULL_WIDTH=1, every trap or software write stores all XLEN bits and reads them back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_vld | input | 1 | Trap write strobe |
| trap_addr | input | XLEN | Faulting virtual address for the trap write |
| csr_we | input | 1 | Software write strobe |
| csr_wdata | input | XLEN | Software write data |
| rd_data | output | XLEN | Sign-extended register value |

## Verification
If the extra bit is wrong, the error shows up on the first read after the write. It appears as all XLEN-VASIZE upper bits flipping together, so a negative valid address reads back as positive, or an invalid address reads back as valid. If the low storage is wrong, only the low bits of the same readback differ. A bad write priority shows up in the cycle after a collision as the software data instead of the trap address. The bench compares both variants against its model on every clock, so any of these faults is reported within one cycle of the write that causes it.

// File: rtl/tval_pkg.sv
package tval_pkg;

  typedef enum logic [1:0] {
    WR_NONE = 2'd0,
    WR_TRAP = 2'd1,
    WR_SW   = 2'd2
  } wr_src_e;

endpackage

// File: rtl/tval_wsel.sv
module tval_wsel #(
  parameter int XLEN = 64
) (
  input  logic                  trap_vld,
  input  logic [XLEN-1:0]       trap_addr,
  input  logic                  csr_we,
  input  logic [XLEN-1:0]       csr_wdata,
  output tval_pkg::wr_src_e     src,
  output logic [XLEN-1:0]       wdata,
  output logic                  wen
);
  import tval_pkg::*;

  // Trap path has priority over software path.
  always_comb begin
    if (trap_vld) begin
      src   = WR_TRAP;
      wdata = trap_addr;
    end else if (csr_we) begin
      src   = WR_SW;
      wdata = csr_wdata;
    end else begin
      src   = WR_NONE;
      wdata = '0;
    end
  end

  assign wen = (src != WR_NONE);

endmodule

// File: rtl/tval_encode.sv
module tval_encode #(
  parameter int XLEN       = 64,
  parameter int VASIZE     = 39,
  parameter bit FULL_WIDTH = 1'b0,
  localparam int SW        = FULL_WIDTH ? XLEN : VASIZE + 1
) (
  input  tval_pkg::wr_src_e src,
  input  logic [XLEN-1:0]   wdata,
  output logic [SW-1:0]     enc
);
  import tval_pkg::*;

  generate
    if (FULL_WIDTH) begin : g_full
      assign enc = wdata;
    end else begin : g_cmp
      localparam int UW = XLEN - VASIZE;
      logic top_bit;
      logic ext_ok;
      logic sign_bit;

      assign top_bit  = wdata[VASIZE-1];
      assign ext_ok   = (wdata[XLEN-1:VASIZE] == {UW{top_bit}});
      // Software data is always taken as valid; traps flag a bad extension.
      assign sign_bit = ((src == WR_TRAP) && !ext_ok) ? ~top_bit : top_bit;
      assign enc      = {sign_bit, wdata[VASIZE-1:0]};
    end
  endgenerate

endmodule

// File: rtl/tval_store.sv
module tval_store #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wen,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (wen) begin
      q <= din;
    end
  end

endmodule

// File: rtl/tval_expand.sv
module tval_expand #(
  parameter int XLEN = 64,
  parameter int SW   = 40
) (
  input  logic [SW-1:0]   stored,
  output logic [XLEN-1:0] rd
);

  for (genvar i = 0; i < XLEN; i++) begin : g_bit
    if (i < SW) begin : g_keep
      assign rd[i] = stored[i];
    end else begin : g_sext
      assign rd[i] = stored[SW-1];
    end
  end

endmodule

// File: rtl/tval_compress_reg.sv
module tval_compress_reg #(
  parameter int XLEN       = 64,
  parameter int VASIZE     = 39,
  parameter bit FULL_WIDTH = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            trap_vld,
  input  logic [XLEN-1:0] trap_addr,
  input  logic            csr_we,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] rd_data
);
  import tval_pkg::*;

  localparam int SW = FULL_WIDTH ? XLEN : VASIZE + 1;

  wr_src_e         src;
  logic [XLEN-1:0] wdata;
  logic            wen;
  logic [SW-1:0]   enc;
  logic [SW-1:0]   stored;

  tval_wsel #(.XLEN(XLEN)) u_wsel (
    .trap_vld (trap_vld),
    .trap_addr(trap_addr),
    .csr_we   (csr_we),
    .csr_wdata(csr_wdata),
    .src      (src),
    .wdata    (wdata),
    .wen      (wen)
  );

  tval_encode #(.XLEN(XLEN), .VASIZE(VASIZE), .FULL_WIDTH(FULL_WIDTH)) u_enc (
    .src  (src),
    .wdata(wdata),
    .enc  (enc)
  );

  tval_store #(.W(SW)) u_store (
    .clk (clk),
    .rst (rst),
    .wen (wen),
    .din (enc),
    .q   (stored)
  );

  tval_expand #(.XLEN(XLEN), .SW(SW)) u_exp (
    .stored(stored),
    .rd    (rd_data)
  );

  AST_RST_CLEAR: assert property (@(posedge clk) rst |=> rd_data == '0); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!trap_vld && !csr_we) |=> $stable(rd_data)); // R6

  generate
    if (FULL_WIDTH) begin : g_chk_full
      AST_FULL_EXACT: assert property (@(posedge clk) disable iff (rst)
        trap_vld |=> rd_data == $past(trap_addr)); // R8
    end else begin : g_chk_cmp
      localparam int UW = XLEN - VASIZE;
      logic in_ext_ok;
      logic rd_ext_ok;
      assign in_ext_ok = (trap_addr[XLEN-1:VASIZE] == {UW{trap_addr[VASIZE-1]}});
      assign rd_ext_ok = (rd_data[XLEN-1:VASIZE] == {UW{rd_data[VASIZE-1]}});

      AST_VALID_EXACT: assert property (@(posedge clk) disable iff (rst)
        (trap_vld && in_ext_ok) |=> rd_data == $past(trap_addr)); // R2

      AST_INVALID_KEPT: assert property (@(posedge clk) disable iff (rst)
        (trap_vld && !in_ext_ok) |=>
          (!rd_ext_ok && rd_data[VASIZE-1:0] == $past(trap_addr[VASIZE-1:0]))); // R3

      AST_SW_AS_VALID: assert property (@(posedge clk) disable iff (rst)
        (csr_we && !trap_vld) |=>
          (rd_ext_ok && rd_data[VASIZE-1:0] == $past(csr_wdata[VASIZE-1:0]))); // R4

      AST_TRAP_WINS: assert property (@(posedge clk) disable iff (rst)
        (csr_we && trap_vld) |=>
          rd_data[VASIZE-1:0] == $past(trap_addr[VASIZE-1:0])); // R5
    end
  endgenerate

endmodule

// File: tb/sim_tval_compress_reg.sv
module sim_tval_compress_reg;
  localparam int XLEN     = 64;
  localparam int VASIZE   = 39;
  localparam int SH       = XLEN - VASIZE;
  localparam int CLK_HALF = 5;
  localparam int WDOG     = 50000;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            trap_vld = 1'b0;
  logic [XLEN-1:0] trap_addr = '0;
  logic            csr_we = 1'b0;
  logic [XLEN-1:0] csr_wdata = '0;
  logic [XLEN-1:0] rd0, rd1;

  logic [XLEN-1:0] exp0 = '0, exp1 = '0;
  int   checks = 0, fails = 0, cyc = 0;
  bit   started = 1'b0, done = 1'b0;
  string req = "R1";

  always #CLK_HALF clk = ~clk;

  tval_compress_reg #(.XLEN(XLEN), .VASIZE(VASIZE), .FULL_WIDTH(1'b0)) u0 (
    .clk(clk), .rst(rst), .trap_vld(trap_vld), .trap_addr(trap_addr),
    .csr_we(csr_we), .csr_wdata(csr_wdata), .rd_data(rd0));

  tval_compress_reg #(.XLEN(XLEN), .VASIZE(VASIZE), .FULL_WIDTH(1'b1)) u1 (
    .clk(clk), .rst(rst), .trap_vld(trap_vld), .trap_addr(trap_addr),
    .csr_we(csr_we), .csr_wdata(csr_wdata), .rd_data(rd1));

  function automatic logic [XLEN-1:0] sext_low(input logic [XLEN-1:0] a);
    logic signed [XLEN-1:0] t;
    t = a << SH;
    return t >>> SH;
  endfunction

  function automatic logic [XLEN-1:0] trap_ref(input logic [XLEN-1:0] a);
    if (sext_low(a) == a) return a;
    return sext_low(a) ^ ({XLEN{1'b1}} << VASIZE);
  endfunction

  // Reference model, updated at the same edge as the design.
  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      exp0 <= '0;
      exp1 <= '0;
    end else if (trap_vld) begin
      exp0 <= trap_ref(trap_addr);
      exp1 <= trap_addr;
    end else if (csr_we) begin
      exp0 <= sext_low(csr_wdata);
      exp1 <= csr_wdata;
    end
  end

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    if (started && !done) begin
      checks++;
      if (rd0 !== exp0) begin
        fails++;
        $display("FAIL %s compressed: actual %h expected %h", req, rd0, exp0);
      end
      checks++;
      if (rd1 !== exp1) begin
        fails++;
        $display("FAIL R8 %s full-width: actual %h expected %h", req, rd1, exp1);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, WDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic drive(input logic tv, input logic [XLEN-1:0] ta,
                       input logic cw, input logic [XLEN-1:0] cd, input string r);
    @(negedge clk);
    #1;
    req = r; trap_vld = tv; trap_addr = ta; csr_we = cw; csr_wdata = cd;
    @(negedge clk);
    #1;
    trap_vld = 1'b0; csr_we = 1'b0;
  endtask

  task automatic idle(input int n, input string r);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
      req = r; trap_vld = 1'b0; csr_we = 1'b0;
      trap_addr = {$urandom, $urandom}; csr_wdata = {$urandom, $urandom};
    end
  endtask

  initial begin
    req = "R1";
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    // R2: valid addresses, including both extremes
    drive(1, 64'h0000_0012_3456_789A, 0, '0, "R2");
    drive(1, 64'hFFFF_FFC0_0000_1000, 0, '0, "R2");
    drive(1, 64'h0000_003F_FFFF_FFFF, 0, '0, "R2");
    drive(1, 64'hFFFF_FFC0_0000_0000, 0, '0, "R2");
    drive(1, 64'h0, 0, '0, "R2");
    // R3: improperly extended addresses
    drive(1, 64'h0000_0040_0000_0000, 0, '0, "R3");
    drive(1, 64'hFFFF_FF80_0000_0000, 0, '0, "R3");
    drive(1, 64'h8000_0000_0000_0005, 0, '0, "R3");
    drive(1, 64'h0000_0080_0000_0001, 0, '0, "R3");
    // R4: software data is taken as valid
    drive(0, '0, 1, 64'hDEAD_BEEF_CAFE_F00D, "R4");
    drive(0, '0, 1, 64'h8000_0000_0000_0001, "R4");
    drive(0, '0, 1, 64'hFFFF_FFFF_FFFF_FFFF, "R4");
    // R5: collision, trap wins
    drive(1, 64'h0000_0001_0000_0002, 1, 64'hFFFF_FFFF_0000_0000, "R5");
    drive(1, 64'h4000_0000_0000_0000, 1, 64'h0000_0000_0000_0033, "R5");
    // R6: hold with strobes low and busy data buses
    idle(6, "R6");
    // R7: visible only after the edge
    drive(0, '0, 1, 64'h0000_0000_1234_0000, "R7");
    idle(2, "R7");
    // mixed traffic
    for (int k = 0; k < 300; k++) begin
      drive(1'($urandom), {$urandom, $urandom} >> ($urandom % 40),
            1'($urandom), {$urandom, $urandom}, "MIX");
    end
    // R1: reset mid-run clears the value
    @(negedge clk);
    #1 req = "R1"; rst = 1'b1;
    repeat (2) @(negedge clk);
    #1 rst = 1'b0;
    idle(2, "R1");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule